// File: doc/BRIEF.md
# Fracturable Three-Input Lookup Table

This block is a programmable lookup table with three data inputs. It can act as one 3-input function. It can also be split into two 2-input functions that share the two low inputs. The eight truth-table bits and one mode bit are loaded serially through a configuration shift chain. The chain has a scan input, a scan output and a shift enable. Several tables can therefore be daisy-chained on one configuration path. Outside of loading, the table is purely combinational: outputs follow the data inputs with no clock involved.

Selection uses a binary multiplexer tree:

- The lowest input steers the first stage.
- The middle input steers the second stage.
- An effective top input steers the final stage. This effective input is the OR of the external top input and the inverted mode bit. When the mode bit is 0, the effective top input is forced high.

The two second-stage results are brought out as half outputs, one per 2-input sub-table. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or data wire.

Top module: `frac_lut3`

## Requirements
- R1: An active-low `rst_n` clears all nine configuration bits to 0. After reset, `lut_out`, `half_out` and `cfg_scan_out` are all 0, and the table is in dual 2-input mode.
- R2: At each rising clock edge with `cfg_shift_en` high, the chain moves one place. `cfg_scan_in` enters the first position. Loading takes nine shifts, sending the mode bit first and then truth-table bits 7 down to 0; truth-table bit i is then selected by input value i.
- R3: With `cfg_shift_en` low, the stored configuration is held whatever `cfg_scan_in` does.
- R4: `half_out[0]` equals truth-table bit {lut_in[1],lut_in[0]}. `half_out[1]` equals truth-table bit 4+{lut_in[1],lut_in[0]}. Both hold in either mode.
- R5: With mode bit 1 (single 3-input mode), `lut_out` equals truth-table bit {lut_in[2],lut_in[1],lut_in[0]}.
- R6: With mode bit 0 (dual mode), `lut_in[2]` has no effect, and `lut_out` equals `half_out[1]`.
- R7: `cfg_scan_out` presents the last chain position, which holds the mode bit. Shifting nine more bits therefore emits the previous contents in load order: the mode bit first, then truth-table bits 7 down to 0.
- R8: Outputs respond to a change of `lut_in` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration chain clock |
| rst_n | input | 1 | Asynchronous active-low reset of the chain |
| cfg_shift_en | input | 1 | Shift the chain one place per rising edge |
| cfg_scan_in | input | 1 | Serial configuration data in |
| cfg_scan_out | output | 1 | Serial configuration data out (last chain position) |
| lut_in | input | 3 | Lookup address inputs |
| lut_out | output | 1 | Full table output |
| half_out | output | 2 | Outputs of the two 2-input sub-tables |

## Verification
Random truth tables are loaded in both modes, and every one of the eight input values is applied. This separates a correct address decode from swapped stage selects or a misplaced tap.

Dual-mode patterns toggle only the top input. These show that it is ignored and that the main output follows the upper sub-table.

Directed one-hot and all-ones tables, together with a nine-bit drain of the chain, pin down the bit order of loading and the daisy-chain output. A held-enable phase with scan activity confirms that the stored configuration does not move.

// File: rtl/frac_lut3_pkg.sv
package frac_lut3_pkg;
  // Flat heap layout of the multiplexer tree: level 0 holds the truth
  // table, each later level holds half as many nodes, level K is the root.
  function automatic int level_base(input int tt_bits, input int lvl);
    return (2 * tt_bits) - ((2 * tt_bits) >> lvl);
  endfunction

  function automatic int tree_nodes(input int tt_bits);
    return (2 * tt_bits) - 1;
  endfunction
endpackage

// File: rtl/frac_lut3_cfg_chain.sv
module frac_lut3_cfg_chain #(
  parameter int LEN = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           scan_in,
  output logic [LEN-1:0] cfg,
  output logic           scan_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (shift_en) begin
      cfg <= {cfg[LEN-2:0], scan_in};
    end
  end

  assign scan_out = cfg[LEN-1];

  // R2: serial bit lands in the first position
  a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cfg[0] == $past(scan_in));

  // R7: scan output presents what sat one place earlier
  a_r7_scan_out_order: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> scan_out == $past(cfg[LEN-2]));

  // R3: chain holds while shifting is off
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg));
endmodule

// File: rtl/frac_lut3_mux_tree.sv
module frac_lut3_mux_tree #(
  parameter int K = 3
) (
  input  logic [(1<<K)-1:0] table_bits,
  input  logic [K-1:0]      sel,
  output logic              root,
  output logic [1:0]        taps
);
  import frac_lut3_pkg::*;

  localparam int TT_BITS = 1 << K;
  localparam int NODES   = tree_nodes(TT_BITS);

  logic [NODES-1:0] node;

  assign node[TT_BITS-1:0] = table_bits;

  for (genvar l = 1; l <= K; l++) begin : g_level
    localparam int BASE_IN  = level_base(TT_BITS, l - 1);
    localparam int BASE_OUT = level_base(TT_BITS, l);
    localparam int COUNT    = TT_BITS >> l;
    for (genvar j = 0; j < COUNT; j++) begin : g_node
      assign node[BASE_OUT + j] = sel[l-1] ? node[BASE_IN + 2*j + 1]
                                           : node[BASE_IN + 2*j];
    end
  end

  localparam int TAP_BASE = level_base(TT_BITS, K - 1);

  assign taps = node[TAP_BASE +: 2];
  assign root = node[NODES-1];
endmodule

// File: rtl/frac_lut3_mode_gate.sv
module frac_lut3_mode_gate (
  input  logic top_in,
  input  logic mode_single,
  output logic top_eff
);
  // Dual mode (mode 0) forces the top select high; single mode passes it.
  assign top_eff = top_in | ~mode_single;
endmodule

// File: rtl/frac_lut3.sv
module frac_lut3 #(
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_shift_en,
  input  logic         cfg_scan_in,
  output logic         cfg_scan_out,
  input  logic [K-1:0] lut_in,
  output logic         lut_out,
  output logic [1:0]   half_out
);
  localparam int TT_BITS   = 1 << K;
  localparam int CHAIN_LEN = TT_BITS + 1;

  logic [CHAIN_LEN-1:0] cfg;
  logic                 mode_single;
  logic                 top_eff;
  logic [K-1:0]         sel;

  frac_lut3_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift_en),
    .scan_in  (cfg_scan_in),
    .cfg      (cfg),
    .scan_out (cfg_scan_out)
  );

  assign mode_single = cfg[CHAIN_LEN-1];

  frac_lut3_mode_gate u_gate (
    .top_in      (lut_in[K-1]),
    .mode_single (mode_single),
    .top_eff     (top_eff)
  );

  assign sel = {top_eff, lut_in[K-2:0]};

  frac_lut3_mux_tree #(.K(K)) u_tree (
    .table_bits (cfg[TT_BITS-1:0]),
    .sel        (sel),
    .root       (lut_out),
    .taps       (half_out)
  );

  // R6: dual mode routes the upper sub-table to the main output
  a_r6_dual_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_single |-> lut_out == half_out[1]);

  // R5: single mode with top input low picks the lower sub-table
  a_r5_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_single && !lut_in[K-1]) |-> lut_out == half_out[0]);

  // R5: single mode with top input high picks the upper sub-table
  a_r5_single_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_single && lut_in[K-1]) |-> lut_out == half_out[1]);
endmodule

// File: tb/frac_lut3_bench.sv
module frac_lut3_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_shift_en = 1'b0;
  logic       cfg_scan_in = 1'b0;
  logic       cfg_scan_out;
  logic [2:0] lut_in = 3'd0;
  logic       lut_out;
  logic [1:0] half_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  frac_lut3 u_frac_lut3 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_shift_en (cfg_shift_en),
    .cfg_scan_in  (cfg_scan_in),
    .cfg_scan_out (cfg_scan_out),
    .lut_in       (lut_in),
    .lut_out      (lut_out),
    .half_out     (half_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_full(input logic [7:0] tt, input logic mode,
                                    input logic [2:0] a);
    logic [2:0] idx;
    idx = {a[2] | ~mode, a[1:0]};
    return tt[idx];
  endfunction

  function automatic logic [1:0] exp_half(input logic [7:0] tt, input logic [2:0] a);
    return {tt[{1'b1, a[1:0]}], tt[{1'b0, a[1:0]}]};
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic load(input logic [7:0] tt, input logic mode);
    logic [8:0] word;
    word = {mode, tt};
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_scan_in  = word[i];
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    cfg_scan_in  = 1'b0;
  endtask

  task automatic sweep(input string req, input logic [7:0] tt, input logic mode);
    for (int a = 0; a < 8; a++) begin
      lut_in = 3'(a);
      #1;
      check(req, lut_out, exp_full(tt, mode, 3'(a)));
      check("R4", half_out, exp_half(tt, 3'(a)));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] tt;
    logic       mode;
    logic [8:0] prev;
    logic [8:0] seen;
    void'($urandom(32'd20240917));

    // R1: reset state
    repeat (3) @(negedge clk);
    lut_in = 3'd5;
    #1;
    check("R1 lut_out", lut_out, 0);
    check("R1 half_out", half_out, 0);
    check("R1 scan_out", cfg_scan_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: combinational response between clock edges
    load(8'b0000_0100, 1'b1);
    lut_in = 3'd2;
    #1;
    check("R8 lut_out high", lut_out, 1);
    lut_in = 3'd3;
    #1;
    check("R8 lut_out low", lut_out, 0);

    // R2: one-hot tables pin down bit order
    for (int b = 0; b < 8; b++) begin
      load(8'(1 << b), 1'b1);
      sweep("R2/R5 onehot", 8'(1 << b), 1'b1);
    end

    // R6: dual mode ignores top input
    load(8'b1010_0110, 1'b0);
    for (int a = 0; a < 4; a++) begin
      lut_in = 3'(a);
      #1;
      check("R6 top low", lut_out, exp_full(8'b1010_0110, 1'b0, 3'(a)));
      lut_in = 3'(a + 4);
      #1;
      check("R6 top high", lut_out, half_out[1]);
    end
    sweep("R6", 8'b1010_0110, 1'b0);

    // R3: hold while enable low, scan_in toggling
    load(8'b1100_1001, 1'b1);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      cfg_scan_in = ~cfg_scan_in;
    end
    cfg_scan_in = 1'b0;
    sweep("R3 hold", 8'b1100_1001, 1'b1);

    // R7: drain nine bits, observe previous contents in load order
    prev = {1'b1, 8'b1100_1001};
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk);
      #1;
      seen[i] = cfg_scan_out;
      cfg_shift_en = 1'b1;
      cfg_scan_in  = 1'b1;
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    check("R7 drained word", seen, prev);
    sweep("R2 all ones", 8'hFF, 1'b1);

    // Random tables in both modes
    for (int n = 0; n < 24; n++) begin
      tt   = 8'($urandom);
      mode = 1'($urandom);
      load(tt, mode);
      sweep(mode ? "R5 random" : "R6 random", tt, mode);
    end

    // R1: reset in mid-use returns to cleared dual mode
    rst_n = 1'b0;
    #1;
    lut_in = 3'd7;
    #1;
    check("R1 re-reset lut_out", lut_out, 0);
    check("R1 re-reset scan_out", cfg_scan_out, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule